// File: doc/BRIEF.md
# Lock-Aware Multiplexed Digit Display

This block scans a six-position common-cathode seven-segment display, one position at a time, and picks what each position shows from the state of a code lock. When the lock is open, or when a new code is being entered in set mode, the stored code digits are shown on the rightmost positions. The first stored digit sits furthest left and the last one sits on the rightmost position. When the lock is closed, the digit values stay hidden: a dash is lit for each digit keyed in so far, growing from the right edge.

A select line is active low. Positions that carry nothing keep their select line high and their segments off. Each time the scan moves to a new position, the segment bus is forced off for one clock, so the previous pattern cannot bleed onto the newly selected digit. The scan rate is set by a divider parameter. The default divider gives one step per 500 Hz tick from a 50 MHz clock.

Top module: `lock_digit_display`

## Requirements
- R1: While reset is held, the segment bus is all zeros. After reset is released, the scan starts at position 0 (the rightmost digit) with its step counter at zero.
- R2: The scanned position advances by one every STEP_CYCLES clocks, running 0,1,...,5 and then wrapping to 0. At most one select line is low at any time, and select bit p belongs to position p.
- R3: In the clock after the scanned position changes, and in the first clock after reset, the segment bus is all zeros whatever the position would otherwise show.
- R4: When unlocked, position p is lit for p < L, where L is the code length. It shows stored digit slot L-1-p, with slot k held in digits_i[4k+3:4k].
- R5: Set mode shows stored digits exactly as R4 does, even while the lock flag is set.
- R6: A position that is not lit drives its select line high, and the segment bus is all zeros while it is scanned.
- R7: When locked and not in set mode, position p is lit for p < N, where N is the entered count. A lit position shows only segment g (0000001), whatever the stored digit values are.
- R8: When locked with an entered count of zero, every position is dark (select all ones, segments all zeros).
- R9: The segment bus is ordered a..g with g in bit 0. The digit codes are: 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1111011.
- R10: A stored digit value from 10 to 15 on a lit position gives all segments off, while its select line stays low.
- R11: An entered count or code length above 6 is treated as 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| locked_i | input | 1 | Lock closed flag |
| set_mode_i | input | 1 | Code entry in progress; shows digits |
| entered_cnt_i | input | 3 | Digits keyed in while locked |
| code_len_i | input | 3 | Active code length |
| digits_i | input | 24 | Six stored 4-bit digits, slot 0 in the low bits |
| seg_o | output | 7 | Segments a..g, g is bit 0, high lights |
| sel_n_o | output | 6 | Active-low position select, bit 0 is rightmost |

## Verification
The scoreboard tracks the scan position and the blanking clock from the clock count alone. It predicts every output vector in every cycle, across full scans in each mode. Reversed digit placement would show up as a code read backwards across the positions. A missing blanking cycle would leave segments lit on the first clock of each new position. Hiding positions wrongly would either light unused positions or leak digit values while locked. The cases that get the most attention are a zero entered count, set mode overriding the lock, stored values above nine that must blank their segments, and counts above six that must saturate rather than wrap.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [6:0] SEG_DASH = 7'b0000001;
  localparam logic [6:0] SEG_OFF  = 7'b0000000;

  function automatic logic [6:0] seg_of(input logic [DIGIT_W-1:0] v);
    logic [6:0] s;
    case (v)
      4'd0: s = 7'b1111110;
      4'd1: s = 7'b0110000;
      4'd2: s = 7'b1101101;
      4'd3: s = 7'b1111001;
      4'd4: s = 7'b0110011;
      4'd5: s = 7'b1011011;
      4'd6: s = 7'b1011111;
      4'd7: s = 7'b1110000;
      4'd8: s = 7'b1111111;
      4'd9: s = 7'b1111011;
      default: s = SEG_OFF;
    endcase
    return s;
  endfunction

  // Saturate a count to the number of display positions.
  function automatic int unsigned sat_count(input int unsigned v, input int unsigned lim);
    return (v > lim) ? lim : v;
  endfunction
endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int NUM_POS     = 6,
  parameter int STEP_CYCLES = 100000,
  localparam int IDX_W = $clog2(NUM_POS + 1),
  localparam int TW    = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] pos_o,
  output logic             blank_o,
  output logic             step_o
);
  logic [TW-1:0]    tick_q;
  logic [IDX_W-1:0] pos_q;
  logic             blank_q;

  assign step_o = (tick_q == TW'(STEP_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q  <= '0;
      pos_q   <= '0;
      blank_q <= 1'b1;
    end else if (step_o) begin
      tick_q  <= '0;
      pos_q   <= (pos_q == IDX_W'(NUM_POS - 1)) ? '0 : pos_q + 1'b1;
      blank_q <= 1'b1;
    end else begin
      tick_q  <= tick_q + 1'b1;
      blank_q <= 1'b0;
    end
  end

  assign pos_o   = pos_q;
  assign blank_o = blank_q;

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> (pos_q != $past(pos_q)));
  p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < IDX_W'(NUM_POS));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_o |=> $stable(pos_q));
endmodule

// File: rtl/slot_select.sv
module slot_select
  import disp_pkg::*;
#(
  parameter int NUM_POS = 6,
  localparam int IDX_W = $clog2(NUM_POS + 1)
) (
  input  logic [IDX_W-1:0]           pos_i,
  input  logic                       show_digits_i,
  input  logic [IDX_W-1:0]           entered_i,
  input  logic [IDX_W-1:0]           len_i,
  input  logic [NUM_POS*DIGIT_W-1:0] digits_i,
  output logic                       active_o,
  output logic [DIGIT_W-1:0]         value_o
);
  logic [IDX_W-1:0] lim;
  logic [IDX_W-1:0] idx;

  always_comb begin
    lim = show_digits_i ? IDX_W'(sat_count(int'(len_i), NUM_POS))
                        : IDX_W'(sat_count(int'(entered_i), NUM_POS));
    active_o = (pos_i < lim);
    idx = lim - 1'b1 - pos_i;
    value_o = '0;
    for (int k = 0; k < NUM_POS; k++) begin
      if (idx == IDX_W'(k)) value_o = digits_i[k*DIGIT_W +: DIGIT_W];
    end
  end
endmodule

// File: rtl/seg_driver.sv
module seg_driver
  import disp_pkg::*;
#(
  parameter int NUM_POS = 6,
  localparam int IDX_W = $clog2(NUM_POS + 1)
) (
  input  logic [IDX_W-1:0]   pos_i,
  input  logic               active_i,
  input  logic               blank_i,
  input  logic               show_digits_i,
  input  logic [DIGIT_W-1:0] value_i,
  output logic [6:0]         seg_o,
  output logic [NUM_POS-1:0] sel_n_o
);
  logic [6:0] pattern;

  assign pattern = show_digits_i ? seg_of(value_i) : SEG_DASH;

  generate
    for (genvar p = 0; p < NUM_POS; p++) begin : g_sel
      assign sel_n_o[p] = !(active_i && (pos_i == IDX_W'(p)));
    end
  endgenerate

  assign seg_o = (active_i && !blank_i) ? pattern : SEG_OFF;

  always_comb begin
    a_dark_seg_off_r6: assert (!(sel_n_o == '1 && seg_o != SEG_OFF));
  end
endmodule

// File: rtl/lock_digit_display.sv
module lock_digit_display
  import disp_pkg::*;
#(
  parameter int NUM_POS     = 6,
  parameter int STEP_CYCLES = 100000,
  localparam int IDX_W = $clog2(NUM_POS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       locked_i,
  input  logic                       set_mode_i,
  input  logic [IDX_W-1:0]           entered_cnt_i,
  input  logic [IDX_W-1:0]           code_len_i,
  input  logic [NUM_POS*DIGIT_W-1:0] digits_i,
  output logic [6:0]                 seg_o,
  output logic [NUM_POS-1:0]         sel_n_o
);
  logic [IDX_W-1:0]   pos_w;
  logic               blank_w;
  logic               step_w;
  logic               show_digits_w;
  logic               active_w;
  logic [DIGIT_W-1:0] value_w;

  assign show_digits_w = !locked_i || set_mode_i;

  scan_timer #(.NUM_POS(NUM_POS), .STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .pos_o  (pos_w),
    .blank_o(blank_w),
    .step_o (step_w)
  );

  slot_select #(.NUM_POS(NUM_POS)) u_slot (
    .pos_i        (pos_w),
    .show_digits_i(show_digits_w),
    .entered_i    (entered_cnt_i),
    .len_i        (code_len_i),
    .digits_i     (digits_i),
    .active_o     (active_w),
    .value_o      (value_w)
  );

  seg_driver #(.NUM_POS(NUM_POS)) u_drv (
    .pos_i        (pos_w),
    .active_i     (active_w),
    .blank_i      (blank_w),
    .show_digits_i(show_digits_w),
    .value_i      (value_w),
    .seg_o        (seg_o),
    .sel_n_o      (sel_n_o)
  );

  p_one_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sel_n_o));
  p_blank_on_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_w != $past(pos_w)) |-> (seg_o == SEG_OFF));
  p_dash_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_i && !set_mode_i) |-> (seg_o == SEG_OFF || seg_o == SEG_DASH));
  p_zero_count_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_i && !set_mode_i && entered_cnt_i == '0) |-> (sel_n_o == '1));
endmodule

// File: tb/tb_lock_digit_display.sv
module tb_lock_digit_display;
  localparam int NP = 6;
  localparam int SC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        locked = 1'b1;
  logic        setm = 1'b0;
  logic [2:0]  cnt = 3'd0;
  logic [2:0]  len = 3'd0;
  logic [23:0] dig = '0;
  logic [6:0]  seg;
  logic [5:0]  sel_n;

  typedef struct {
    logic [6:0] seg;
    logic [5:0] sel;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  int   n_cyc = 0;

  always #10 clk = ~clk;

  lock_digit_display #(.NUM_POS(NP), .STEP_CYCLES(SC)) dut (
    .clk(clk), .rst_n(rst_n), .locked_i(locked), .set_mode_i(setm),
    .entered_cnt_i(cnt), .code_len_i(len), .digits_i(dig),
    .seg_o(seg), .sel_n_o(sel_n)
  );

  function automatic logic [6:0] code_for(input int v);
    case (v)
      0: return 7'b1111110; 1: return 7'b0110000; 2: return 7'b1101101;
      3: return 7'b1111001; 4: return 7'b0110011; 5: return 7'b1011011;
      6: return 7'b1011111; 7: return 7'b1110000; 8: return 7'b1111111;
      9: return 7'b1111011;
      default: return 7'b0000000;
    endcase
  endfunction

  // Predict the outputs after c clocks since reset release.
  function automatic exp_t predict(input int c, input string tag);
    exp_t e;
    int p, lim, slot;
    bit blank, digits_mode;
    p = (c / SC) % NP;
    blank = (c % SC) == 0;
    digits_mode = !locked || setm;
    lim = digits_mode ? int'(len) : int'(cnt);
    if (lim > NP) lim = NP;
    e.tag = blank ? "R3" : tag;
    if (p < lim) begin
      e.sel = ~(6'd1 << p);
      slot = lim - 1 - p;
      if (blank) e.seg = 7'd0;
      else if (digits_mode) e.seg = code_for(int'(dig[slot*4 +: 4]));
      else e.seg = 7'b0000001;
    end else begin
      e.sel = 6'h3f;
      e.seg = 7'd0;
    end
    return e;
  endfunction

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (seg !== e.seg || sel_n !== e.sel) begin
        n_bad++;
        $display("FAIL %s: seg=%b sel_n=%b expected seg=%b sel_n=%b",
                 e.tag, seg, sel_n, e.seg, e.sel);
      end
    end
  end

  task automatic run(input bit lk, input bit sm, input int c, input int l,
                     input logic [23:0] d, input int cycles, input string tag);
    locked = lk; setm = sm; cnt = 3'(c); len = 3'(l); dig = d;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      n_cyc++;
      q.push_back(predict(n_cyc, tag));
    end
    @(negedge clk); #1;
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset holds segments off, nothing selected while locked with count 0
    n_vec++;
    if (seg !== 7'd0 || sel_n !== 6'h3f) begin
      n_bad++;
      $display("FAIL R1: seg=%b sel_n=%b expected seg=%b sel_n=%b", seg, sel_n, 7'd0, 6'h3f);
    end
    #1 rst_n = 1'b1;
    n_cyc = 0;
    // R2: full scans with every position lit
    run(1'b0, 1'b0, 0, 6, {6{4'd8}}, 2*NP*SC, "R2");
    // R4 and R9: code 1,2,3,4 on four positions
    run(1'b0, 1'b0, 0, 4, {8'h00, 4'd4, 4'd3, 4'd2, 4'd1}, NP*SC, "R4");
    // R9: remaining codes
    run(1'b0, 1'b0, 0, 6, {4'd0, 4'd9, 4'd8, 4'd7, 4'd6, 4'd5}, NP*SC, "R9");
    // R6: short code leaves upper positions dark
    run(1'b0, 1'b0, 0, 2, {16'h0000, 4'd7, 4'd3}, NP*SC, "R6");
    // R10: values above nine blank their segments
    run(1'b0, 1'b0, 0, 3, {12'h000, 4'd15, 4'd12, 4'd10}, NP*SC, "R10");
    // R7: locked shows dashes only
    run(1'b1, 1'b0, 3, 6, {4'd9, 4'd8, 4'd7, 4'd6, 4'd5, 4'd4}, NP*SC, "R7");
    // R8: locked with zero count is all dark
    run(1'b1, 1'b0, 0, 6, {6{4'd1}}, NP*SC, "R8");
    // R5: set mode overrides the lock flag
    run(1'b1, 1'b1, 2, 5, {4'd0, 4'd2, 4'd4, 4'd6, 4'd8, 4'd1}, NP*SC, "R5");
    // R11: counts above six saturate
    run(1'b1, 1'b0, 7, 7, {6{4'd3}}, NP*SC, "R11");
    run(1'b0, 1'b0, 7, 7, {4'd6, 4'd5, 4'd4, 4'd3, 4'd2, 4'd1}, NP*SC, "R11");
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule